// File: doc/BRIEF.md
# Per-Core Cascaded Interval Tick Timer

This block is a local timer, one copy per processor core. It is built from two down-counters in series. The first counter is a prescaler: it turns the input clock into a slower tick. The second counter counts those ticks and flags an interrupt when its count runs out. In one-shot operation the second counter disarms after it expires. In interval operation it reloads from its buffer and keeps firing until software stops it.

Software sets the timer up through a simple 32-bit write bus with a combinational read path. Each copy owns a 256-byte address window whose base depends on the parameter `INST_IDX`. The interrupt-count buffer can be written in two ways. A write with the update flag set schedules a load of the running counter on the next tick. A plain write changes only the buffered value. Writes to the buffered registers raise sticky acknowledge bits, and software clears these bits by writing 1.

Top module: `core_tick_timer`

## Requirements
- R1: Only writes whose address lies in the window starting at 0x300 + 0x100·INST_IDX (offset in the low 8 bits) take effect. Writes outside the window change nothing, and reads outside it return 0.
- R2: While the run bit (control offset 0x20, bit 0) is set, a tick occurs once every P+1 clocks, where P is the prescale value at offset 0x00. A write to 0x00 also restarts the prescaler count from P.
- R3: A write to offset 0x08 with bit 31 set stores bits 30:0 as the buffered count and marks an update as pending. On the next tick the pending count is loaded into the active counter and the counter is armed. Reading 0x08 returns the pending flag in bit 31 and the buffered count in bits 30:0.
- R4: While the count bit (control bit 1) is set, each tick decrements the armed counter. The tick that finds a value of 1 or 0 is an expiry and sets the status bit (offset 0x30, bit 0). With the interval bit (control bit 2) clear, the counter disarms on expiry and raises no further status.
- R5: With the interval bit set, an expiry reloads the counter from the buffered count, so a count N gives an expiry every N ticks.
- R6: A write to 0x08 with bit 31 clear changes only the buffer. The active count continues, and the new value is used from the next reload.
- R7: With the run bit clear, both counters hold their values and no expiry occurs.
- R8: With the run bit set and the count bit clear, ticks continue but the interrupt counter neither counts nor expires.
- R9: Writing 1 to bit 0 of offset 0x30 clears the status bit; when an expiry happens in the same cycle, the set wins. The output `tick_irq` is high when the status bit and the enable bit (offset 0x34, bit 0) are both set.
- R10: Offset 0x40 holds write acknowledges, each set the cycle after its write: bit 0 for a write to 0x00, bit 1 for a write to 0x08, bit 3 for a write to 0x20. Writing 1 to a bit clears it.
- R11: After reset every register, both counters and `tick_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_irq | output | 1 | Interrupt request: status AND enable |

## Verification
A prescaler that holds a wrong count moves every expiry. The error appears on `tick_irq` at the first expiry after the fault, and it builds up by one or more clocks on every interval period after that. A stuck pending flag or a lost reload either stops the interrupts in interval mode or keeps them coming in one-shot mode. Either case shows up within one programmed period. A bench model that runs cycle by cycle therefore compares `tick_irq` on every clock, and directed reads check the status and acknowledge bits after each phase.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam logic [7:0] OFS_PRESCALE = 8'h00;
    localparam logic [7:0] OFS_COUNT    = 8'h08;
    localparam logic [7:0] OFS_CTRL     = 8'h20;
    localparam logic [7:0] OFS_STATUS   = 8'h30;
    localparam logic [7:0] OFS_ENABLE   = 8'h34;
    localparam logic [7:0] OFS_ACK      = 8'h40;

    typedef struct packed {
        logic interval;
        logic count_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/tt_regs.sv
module tt_regs
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INST_IDX = 0,
    parameter int CNT_W    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              expire,
    input  logic              upd_taken,
    output logic [31:0]       rdata,
    output logic [31:0]       prescale,
    output logic              prescale_load,
    output logic [CNT_W-1:0]  count_buf,
    output logic              upd_pend,
    output ctrl_t             ctrl,
    output logic              irq_stat,
    output logic              irq_en
);
    localparam int BASE      = 'h300 + 'h100 * INST_IDX;
    localparam int PAGE_W    = ADDR_W - 8;
    localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(BASE >> 8);

    typedef struct packed {
        logic [31:0]      prescale;
        logic [CNT_W-1:0] count_buf;
        logic             pend;
        ctrl_t            ctrl;
        logic             stat;
        logic             en;
        logic [2:0]       ack;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;
    logic [7:0] ofs;

    assign ofs = bus_addr[7:0];
    assign hit = (bus_addr[ADDR_W-1:8] == PAGE);

    always_comb begin
        r_d = r_q;
        if (bus_wr && hit) begin
            case (ofs)
                OFS_PRESCALE: begin
                    r_d.prescale = bus_wdata;
                    r_d.ack[0]   = 1'b1;
                end
                OFS_COUNT: begin
                    r_d.count_buf = bus_wdata[CNT_W-1:0];
                    r_d.ack[1]    = 1'b1;
                end
                OFS_CTRL: begin
                    r_d.ctrl   = ctrl_t'(bus_wdata[2:0]);
                    r_d.ack[2] = 1'b1;
                end
                OFS_ENABLE: r_d.en = bus_wdata[0];
                OFS_ACK:    r_d.ack = r_q.ack & ~{bus_wdata[3], bus_wdata[1], bus_wdata[0]};
                default: ;
            endcase
        end
        if (upd_taken)
            r_d.pend = 1'b0;
        if (bus_wr && hit && ofs == OFS_COUNT && bus_wdata[31])
            r_d.pend = 1'b1;
        if (bus_wr && hit && ofs == OFS_STATUS && bus_wdata[0])
            r_d.stat = 1'b0;
        if (expire)
            r_d.stat = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            case (ofs)
                OFS_PRESCALE: rdata = r_q.prescale;
                OFS_COUNT:    rdata = {r_q.pend, r_q.count_buf};
                OFS_CTRL:     rdata = {29'd0, r_q.ctrl};
                OFS_STATUS:   rdata = {31'd0, r_q.stat};
                OFS_ENABLE:   rdata = {31'd0, r_q.en};
                OFS_ACK:      rdata = {28'd0, r_q.ack[2], 1'b0, r_q.ack[1:0]};
                default:      rdata = '0;
            endcase
        end
    end

    assign prescale      = r_q.prescale;
    assign prescale_load = bus_wr && hit && (ofs == OFS_PRESCALE);
    assign count_buf     = r_q.count_buf;
    assign upd_pend      = r_q.pend;
    assign ctrl          = r_q.ctrl;
    assign irq_stat      = r_q.stat;
    assign irq_en        = r_q.en;

    // R9: an expiry from the counter always leaves the status bit set
    a_r9_status_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq_stat);
    // R10: a control write is acknowledged on the next cycle
    a_r10_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && ofs == OFS_CTRL) |=> r_q.ack[2]);
    // R3: a pending update survives until the counter takes it
    a_r3_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !upd_taken) |=> upd_pend);
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    assign tick = run && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (load)
            s_d.cnt = load_val;
        else if (run)
            s_d.cnt = (s_q.cnt == '0) ? reload_val : s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: a stopped prescaler keeps its count
    a_r7_prescale_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(s_q.cnt));
endmodule

// File: rtl/tt_intcount.sv
module tt_intcount #(
    parameter int W = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         count_en,
    input  logic         interval,
    input  logic         upd_pend,
    input  logic [W-1:0] count_buf,
    output logic         upd_taken,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } ic_t;

    ic_t s_d, s_q;
    logic at_end;

    assign at_end    = (s_q.cnt <= W'(1));
    assign upd_taken = tick && upd_pend;
    assign expire    = tick && count_en && s_q.armed && !upd_pend && at_end;

    always_comb begin
        s_d = s_q;
        if (upd_taken) begin
            s_d.cnt   = count_buf;
            s_d.armed = 1'b1;
        end else if (tick && count_en && s_q.armed) begin
            if (at_end) begin
                if (interval) begin
                    s_d.cnt = count_buf;
                end else begin
                    s_d.cnt   = '0;
                    s_d.armed = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a one-shot expiry leaves the counter disarmed
    a_r4_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !interval) |=> !s_q.armed);
    // R5: an interval expiry keeps the counter armed
    a_r5_interval_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && interval) |=> s_q.armed);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import tick_timer_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int INST_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tick_irq
);
    localparam int PRE_W = 32;
    localparam int CNT_W = 31;

    logic [PRE_W-1:0] prescale;
    logic             prescale_load;
    logic [CNT_W-1:0] count_buf;
    logic             upd_pend, upd_taken, expire, tick;
    logic             irq_stat, irq_en;
    ctrl_t            ctrl;

    tt_regs #(.ADDR_W(ADDR_W), .INST_IDX(INST_IDX), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .expire(expire), .upd_taken(upd_taken),
        .rdata(bus_rdata), .prescale(prescale), .prescale_load(prescale_load),
        .count_buf(count_buf), .upd_pend(upd_pend), .ctrl(ctrl),
        .irq_stat(irq_stat), .irq_en(irq_en)
    );

    tt_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .load(prescale_load),
        .load_val(bus_wdata), .reload_val(prescale), .tick(tick)
    );

    tt_intcount #(.W(CNT_W)) u_ic (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(ctrl.count_en),
        .interval(ctrl.interval), .upd_pend(upd_pend), .count_buf(count_buf),
        .upd_taken(upd_taken), .expire(expire)
    );

    assign tick_irq = irq_stat && irq_en;

    // R4: expiries happen only on prescaler ticks
    a_r4_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> tick);
    // R8: with counting disabled no expiry reaches the status logic
    a_r8_no_count_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.count_en |-> !expire);
endmodule

// File: tb/tb_core_tick_timer.sv
module tb_core_tick_timer;
    localparam int ADDR_W = 16;
    localparam int INST   = 1;
    localparam logic [15:0] BASE = 16'h0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int errors = 0;
    int rises  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    core_tick_timer #(.ADDR_W(ADDR_W), .INST_IDX(INST)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    // behavioural reference model
    logic [31:0] m_pre, m_pbuf;
    int unsigned m_ic, m_icbuf;
    bit m_pend, m_run, m_cen, m_int, m_stat, m_en, m_arm;
    bit [3:0] m_ack;
    bit m_irq_prev;

    always @(posedge clk) begin
        bit hit, tk, upd, ex;
        logic [7:0] o;
        if (!rst_n) begin
            m_pre = 0; m_pbuf = 0; m_ic = 0; m_icbuf = 0; m_pend = 0;
            m_run = 0; m_cen = 0; m_int = 0; m_stat = 0; m_en = 0;
            m_arm = 0; m_ack = 0;
        end else begin
            hit = bus_wr && (bus_addr[15:8] == BASE[15:8]);
            o   = bus_addr[7:0];
            tk  = m_run && (m_pre == 0);
            upd = tk && m_pend;
            ex  = tk && m_cen && m_arm && !m_pend && (m_ic <= 1);
            if (hit && o == 8'h00) m_pre = bus_wdata;
            else if (tk) m_pre = m_pbuf;
            else if (m_run) m_pre = m_pre - 1;
            if (upd) begin m_ic = m_icbuf; m_arm = 1; end
            else if (tk && m_cen && m_arm) begin
                if (m_ic <= 1) begin
                    if (m_int) m_ic = m_icbuf; else begin m_ic = 0; m_arm = 0; end
                end else m_ic = m_ic - 1;
            end
            if (upd) m_pend = 0;
            if (hit) begin
                case (o)
                    8'h00: begin m_pbuf = bus_wdata; m_ack[0] = 1; end
                    8'h08: begin m_icbuf = bus_wdata[30:0]; m_ack[1] = 1;
                                 if (bus_wdata[31]) m_pend = 1; end
                    8'h20: begin {m_int, m_cen, m_run} = bus_wdata[2:0]; m_ack[3] = 1; end
                    8'h30: if (bus_wdata[0]) m_stat = 0;
                    8'h34: m_en = bus_wdata[0];
                    8'h40: m_ack = m_ack & ~bus_wdata[3:0];
                    default: ;
                endcase
            end
            if (ex) m_stat = 1;
        end
    end

    // per-cycle comparison of the interrupt output
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (tick_irq !== (m_stat && m_en)) begin
                errors++;
                $display("FAIL R4/R5 tick_irq per-cycle: act=%0d exp=%0d at %0t",
                         tick_irq, m_stat && m_en, $time);
            end
            if (tick_irq && !m_irq_prev) rises++;
            m_irq_prev = tick_irq;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=0x%08h exp=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #1_600_000;
        $display("FAIL watchdog: act=timeout exp=finish");
        errors++;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: reset values
        rd(BASE + 16'h00, v); chk("R11 prescale", v, 0);
        rd(BASE + 16'h08, v); chk("R11 count", v, 0);
        rd(BASE + 16'h20, v); chk("R11 ctrl", v, 0);
        rd(BASE + 16'h30, v); chk("R11 status", v, 0);
        rd(BASE + 16'h40, v); chk("R11 ack", v, 0);
        chk("R11 irq", {31'd0, tick_irq}, 0);

        // R1: writes outside the window ignored
        wr(16'h0300, 32'h55);
        wr(16'h0520, 32'h7);
        rd(BASE + 16'h00, v); chk("R1 prescale untouched", v, 0);
        rd(BASE + 16'h20, v); chk("R1 ctrl untouched", v, 0);
        rd(16'h0300, v); chk("R1 read outside window", v, 0);

        // R10: write acknowledges
        wr(BASE + 16'h00, 32'd2);
        wr(BASE + 16'h34, 32'd1);
        wr(BASE + 16'h08, 32'h8000_0003);
        rd(BASE + 16'h08, v); chk("R3 readback pending", v, 32'h8000_0003);
        wr(BASE + 16'h20, 32'b011);
        rd(BASE + 16'h40, v); chk("R10 ack bits 0,1,3", v, 32'hB);
        wr(BASE + 16'h40, 32'h8);
        rd(BASE + 16'h40, v); chk("R10 clear bit 3", v, 32'h3);

        // R2/R3/R4: one-shot expiry with prescale 2
        idle(40);
        rd(BASE + 16'h08, v); chk("R3 pending consumed", v, 32'h3);
        rd(BASE + 16'h30, v); chk("R4 status set", v, 1);
        chk("R9 irq with enable", {31'd0, tick_irq}, 1);
        wr(BASE + 16'h30, 32'd1);
        idle(60);
        rd(BASE + 16'h30, v); chk("R4 one-shot stays quiet", v, 0);

        // R9: enable gates the output
        wr(BASE + 16'h34, 32'd0);
        wr(BASE + 16'h08, 32'h8000_0001);
        idle(20);
        rd(BASE + 16'h30, v); chk("R9 status without enable", v, 1);
        chk("R9 irq masked", {31'd0, tick_irq}, 0);
        wr(BASE + 16'h30, 32'd1);
        wr(BASE + 16'h34, 32'd1);

        // R5: interval mode with count 2
        wr(BASE + 16'h08, 32'h8000_0002);
        wr(BASE + 16'h20, 32'b111);
        r0 = rises;
        for (int k = 0; k < 8; k++) begin
            idle(6);
            wr(BASE + 16'h30, 32'd1);
        end
        chk("R5 repeated expiries", {31'd0, (rises - r0) >= 3}, 1);

        // R6: plain buffer write
        wr(BASE + 16'h08, 32'h0000_0005);
        rd(BASE + 16'h08, v); chk("R6 buffer only", v, 32'h5);
        for (int k = 0; k < 6; k++) begin
            idle(15);
            wr(BASE + 16'h30, 32'd1);
        end

        // R8: count disabled
        wr(BASE + 16'h20, 32'b101);
        wr(BASE + 16'h30, 32'd1);
        idle(80);
        rd(BASE + 16'h30, v); chk("R8 no expiry without count", v, 0);

        // R7: freeze
        wr(BASE + 16'h20, 32'b110);
        wr(BASE + 16'h30, 32'd1);
        idle(80);
        rd(BASE + 16'h30, v); chk("R7 frozen no expiry", v, 0);
        wr(BASE + 16'h20, 32'b111);
        idle(60);
        rd(BASE + 16'h30, v); chk("R7 resumes after restart", v, 1);

        // R2: large prescale spaces out expiries
        wr(BASE + 16'h20, 32'b000);
        wr(BASE + 16'h00, 32'd9);
        wr(BASE + 16'h08, 32'h8000_0001);
        wr(BASE + 16'h30, 32'd1);
        wr(BASE + 16'h20, 32'b011);
        idle(8);
        rd(BASE + 16'h30, v); chk("R2 not yet expired", v, 0);
        idle(30);
        rd(BASE + 16'h30, v); chk("R2 expired after ticks", v, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule